// File: doc/BRIEF.md
# Debug trigger register bank

This block keeps the configuration of a small, parameterised number of hardware debug trigger slots behind a narrow indexed register window. A select register names one slot. Three data registers then reach that slot's stored words. Register requests arrive as a request strobe with a write flag, a 12-bit register address, write data and two requester-state flags. One flag says the requester is in halt (debug) mode and the other says it is in machine mode. Halt takes precedence when both are set.

Each slot has a type code that is fixed at build time through a parameter. The code is reported in the top four bits of the first data register. Bit XLEN-5 of that register is an ownership bit. While the bit is set, only halt-mode writes reach the slot. Only a halt-mode write can change the bit itself. The full stored words of every slot, type code included, drive flat output buses for the match and count logic that sits outside this block.

Requests are decoded into one of five access classes: none, select, data-1, data-2 and data-3. A read answers combinationally in the cycle of the request. A write takes effect at the next clock edge.

Top module: `dtrig_bank`

## Requirements
- R1: The window holds four addresses. 0x7A0 is the select register, and 0x7A1, 0x7A2 and 0x7A3 are data-1, data-2 and data-3 of the selected slot. `csr_hit` is high only for a request to one of these four addresses. For any other address `csr_rdata` is zero and no state changes.
- R2: Bits XLEN-1..XLEN-4 of data-1 read as the slot's type code. With the default parameters the codes are 2, 2, 3, 15 and 0 for slots 0 to 4 (2 means address/data match, 3 means instruction count, 15 means present but unavailable, 0 means no trigger). Writes never change these bits.
- R3: A permitted write stores the low XLEN-5 bits of data-1, or all of data-2, or all of data-3, at the next clock edge. A read returns the stored value in the same cycle as the request.
- R4: While a slot's ownership bit (data-1 bit XLEN-5) is 1, writes to any of its data registers from a requester not in halt mode are dropped. Halt-mode writes still land.
- R5: The ownership bit takes the written bit XLEN-5 only on a data-1 write from halt mode. A machine-mode write to data-1 leaves the bit unchanged.
- R6: A write from a requester that is in neither halt nor machine mode is dropped for every register, the select register included.
- R7: While the select value is at or beyond the slot count, or names a slot of type 0, the data registers read as zero and writes to them are discarded.
- R8: After reset the select register is 0 and every slot's ownership bit and stored data are 0. The slot output buses then carry only the type codes.
- R9: The select register stores and reads back the full XLEN-bit written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | Register access request |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| req_halt | input | 1 | Requester is in halt (debug) mode |
| req_mach | input | 1 | Requester is in machine mode |
| csr_rdata | output | XLEN | Read data, valid in the request cycle |
| csr_hit | output | 1 | Request targets the trigger window |
| slot_cfg1 | output | NUM_SLOTS*XLEN | Data-1 word of each slot, slot 0 lowest |
| slot_cfg2 | output | NUM_SLOTS*XLEN | Data-2 word of each slot |
| slot_cfg3 | output | NUM_SLOTS*XLEN | Data-3 word of each slot |

## Verification
The bench targets four corner cases.
- A slot locked by its ownership bit receives machine-mode writes to each data register. A design that gates only data-1 would let data-2 or data-3 change.
- A machine-mode data-1 write sets bit XLEN-5. A design that lets it through would lock a slot that halt mode never claimed.
- The select register is driven past the slot count and onto the type-0 slot, then every data register is read and written. Aliasing on the low index bits would show another slot's contents.
- Writes come from requesters in neither halt nor machine mode, and a random mix of modes and owner states is compared against a bench model. A design that ignores requester state would move the select register.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

    localparam logic [11:0] ADDR_SEL = 12'h7A0;
    localparam logic [11:0] ADDR_D1  = 12'h7A1;
    localparam logic [11:0] ADDR_D2  = 12'h7A2;
    localparam logic [11:0] ADDR_D3  = 12'h7A3;

    localparam logic [3:0] TYPE_NONE   = 4'h0;
    localparam logic [3:0] TYPE_MATCH  = 4'h2;
    localparam logic [3:0] TYPE_ICOUNT = 4'h3;
    localparam logic [3:0] TYPE_UNAVL  = 4'hF;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SEL,
        ACC_D1,
        ACC_D2,
        ACC_D3
    } acc_e;

endpackage

// File: rtl/dtrig_decode.sv
module dtrig_decode
    import dtrig_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NUM_SLOTS = 5
) (
    input  logic            req,
    input  logic            we,
    input  logic [11:0]     addr,
    input  logic            halt,
    input  logic            mach,
    input  logic [XLEN-1:0] sel_q,
    output acc_e            acc,
    output logic            wr_ok,
    output logic            idx_ok
);

    always_comb begin
        acc = ACC_NONE;
        if (req) begin
            case (addr)
                ADDR_SEL: acc = ACC_SEL;
                ADDR_D1:  acc = ACC_D1;
                ADDR_D2:  acc = ACC_D2;
                ADDR_D3:  acc = ACC_D3;
                default:  acc = ACC_NONE;
            endcase
        end
    end

    // A write is accepted only from halt or machine requesters
    assign wr_ok  = req && we && (halt || mach);
    assign idx_ok = (sel_q < XLEN'(NUM_SLOTS));

endmodule

// File: rtl/dtrig_slot.sv
module dtrig_slot #(
    parameter int         XLEN      = 32,
    parameter logic [3:0] SLOT_TYPE = 4'h2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt,
    input  logic            wr_d1,
    input  logic            wr_d2,
    input  logic            wr_d3,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] cfg1,
    output logic [XLEN-1:0] cfg2,
    output logic [XLEN-1:0] cfg3
);

    localparam int LOW_W   = XLEN - 5;
    localparam int OWN_BIT = XLEN - 5;

    generate
        if (SLOT_TYPE == 4'h0) begin : g_empty
            logic unused_ins;
            assign unused_ins = ^{clk, rst_n, halt, wr_d1, wr_d2, wr_d3, wdata};
            assign cfg1 = '0;
            assign cfg2 = '0;
            assign cfg3 = '0;
        end else begin : g_store
            logic             own_q;
            logic [LOW_W-1:0] low_q;
            logic [XLEN-1:0]  d2_q;
            logic [XLEN-1:0]  d3_q;
            logic             allow;

            // Ownership lock: a claimed slot listens to halt mode only
            assign allow = !own_q || halt;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    own_q <= 1'b0;
                    low_q <= '0;
                    d2_q  <= '0;
                    d3_q  <= '0;
                end else begin
                    if (wr_d1 && allow) begin
                        low_q <= wdata[LOW_W-1:0];
                        if (halt) own_q <= wdata[OWN_BIT];
                    end
                    if (wr_d2 && allow) d2_q <= wdata;
                    if (wr_d3 && allow) d3_q <= wdata;
                end
            end

            assign cfg1 = {SLOT_TYPE, own_q, low_q};
            assign cfg2 = d2_q;
            assign cfg3 = d3_q;

            // R4: a locked slot ignores every non-halt write
            p_lock_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (own_q && !halt && (wr_d1 || wr_d2 || wr_d3)) |=>
                ($stable(low_q) && $stable(d2_q) && $stable(d3_q) && $stable(own_q)));

            // R5: the ownership bit moves only on a halt-mode data-1 write
            p_own_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !(halt && wr_d1) |=> $stable(own_q));
        end
    endgenerate

endmodule

// File: rtl/dtrig_bank.sv
module dtrig_bank
    import dtrig_pkg::*;
#(
    parameter int                      XLEN       = 32,
    parameter int                      NUM_SLOTS  = 5,
    parameter logic [4*NUM_SLOTS-1:0]  SLOT_TYPES = 20'h0F322
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      csr_req,
    input  logic                      csr_we,
    input  logic [11:0]               csr_addr,
    input  logic [XLEN-1:0]           csr_wdata,
    input  logic                      req_halt,
    input  logic                      req_mach,
    output logic [XLEN-1:0]           csr_rdata,
    output logic                      csr_hit,
    output logic [NUM_SLOTS*XLEN-1:0] slot_cfg1,
    output logic [NUM_SLOTS*XLEN-1:0] slot_cfg2,
    output logic [NUM_SLOTS*XLEN-1:0] slot_cfg3
);

    acc_e            acc;
    logic            wr_ok;
    logic            idx_ok;
    logic [XLEN-1:0] sel_q;
    logic [XLEN-1:0] cfg1_a [NUM_SLOTS];
    logic [XLEN-1:0] cfg2_a [NUM_SLOTS];
    logic [XLEN-1:0] cfg3_a [NUM_SLOTS];
    logic [XLEN-1:0] rd1, rd2, rd3;

    dtrig_decode #(
        .XLEN      (XLEN),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_decode (
        .req    (csr_req),
        .we     (csr_we),
        .addr   (csr_addr),
        .halt   (req_halt),
        .mach   (req_mach),
        .sel_q  (sel_q),
        .acc    (acc),
        .wr_ok  (wr_ok),
        .idx_ok (idx_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_ok && acc == ACC_SEL) begin
            sel_q <= csr_wdata;
        end
    end

    generate
        for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
            logic hit_me;
            assign hit_me = wr_ok && (sel_q == XLEN'(i));

            dtrig_slot #(
                .XLEN      (XLEN),
                .SLOT_TYPE (SLOT_TYPES[4*i +: 4])
            ) u_slot (
                .clk   (clk),
                .rst_n (rst_n),
                .halt  (req_halt),
                .wr_d1 (hit_me && acc == ACC_D1),
                .wr_d2 (hit_me && acc == ACC_D2),
                .wr_d3 (hit_me && acc == ACC_D3),
                .wdata (csr_wdata),
                .cfg1  (cfg1_a[i]),
                .cfg2  (cfg2_a[i]),
                .cfg3  (cfg3_a[i])
            );

            assign slot_cfg1[i*XLEN +: XLEN] = cfg1_a[i];
            assign slot_cfg2[i*XLEN +: XLEN] = cfg2_a[i];
            assign slot_cfg3[i*XLEN +: XLEN] = cfg3_a[i];
        end
    endgenerate

    always_comb begin
        rd1 = '0;
        rd2 = '0;
        rd3 = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sel_q == XLEN'(i)) begin
                rd1 = cfg1_a[i];
                rd2 = cfg2_a[i];
                rd3 = cfg3_a[i];
            end
        end
    end

    always_comb begin
        unique case (acc)
            ACC_SEL:  csr_rdata = sel_q;
            ACC_D1:   csr_rdata = idx_ok ? rd1 : '0;
            ACC_D2:   csr_rdata = idx_ok ? rd2 : '0;
            ACC_D3:   csr_rdata = idx_ok ? rd3 : '0;
            default:  csr_rdata = '0;
        endcase
    end

    assign csr_hit = (acc != ACC_NONE);

    // R6: unprivileged writers cannot move the select register
    p_sel_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && csr_addr == ADDR_SEL && !req_halt && !req_mach)
        |=> $stable(sel_q));

    // R9: a permitted select write is stored in full
    p_sel_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && csr_addr == ADDR_SEL && (req_halt || req_mach))
        |=> (sel_q == $past(csr_wdata)));

    // R7: out-of-range selection reads as zero
    p_oor_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && (sel_q >= XLEN'(NUM_SLOTS)) &&
         (csr_addr == ADDR_D1 || csr_addr == ADDR_D2 || csr_addr == ADDR_D3))
        |-> (csr_rdata == '0));

    // R1: addresses outside the window return zero and no hit
    p_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_addr[11:2] != 10'h1E8) |-> (!csr_hit && csr_rdata == '0));

endmodule

// File: tb/tb_dtrig_bank.sv
module tb_dtrig_bank;

    localparam int XLEN = 32;
    localparam int NS   = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              csr_req = 1'b0;
    logic              csr_we = 1'b0;
    logic [11:0]       csr_addr = '0;
    logic [XLEN-1:0]   csr_wdata = '0;
    logic              req_halt = 1'b0;
    logic              req_mach = 1'b0;
    logic [XLEN-1:0]   csr_rdata;
    logic              csr_hit;
    logic [NS*XLEN-1:0] slot_cfg1, slot_cfg2, slot_cfg3;

    always #4 clk = ~clk;

    dtrig_bank dut (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .req_halt(req_halt),
        .req_mach(req_mach), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .slot_cfg1(slot_cfg1), .slot_cfg2(slot_cfg2), .slot_cfg3(slot_cfg3)
    );

    int nchk = 0;
    int nfail = 0;

    logic [31:0] m_sel;
    logic        m_own [NS];
    logic [26:0] m_low [NS];
    logic [31:0] m_d2  [NS];
    logic [31:0] m_d3  [NS];

    function automatic logic [3:0] ty(int i);
        case (i)
            0, 1:    return 4'h2;
            2:       return 4'h3;
            3:       return 4'hF;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_cfg(int i, int r);
        if (ty(i) == 4'h0) return 32'h0;
        if (r == 1) return {ty(i), m_own[i], m_low[i]};
        if (r == 2) return m_d2[i];
        return m_d3[i];
    endfunction

    function automatic logic [31:0] exp_rd(logic [11:0] a);
        int idx;
        if (a == 12'h7A0) return m_sel;
        if (a < 12'h7A1 || a > 12'h7A3) return 32'h0;
        if (m_sel >= 32'(NS)) return 32'h0;
        idx = int'(m_sel);
        return exp_cfg(idx, int'(a - 12'h7A0));
    endfunction

    task automatic model_wr(logic [11:0] a, logic [31:0] wd, bit h, bit m);
        int idx;
        if (!(h || m)) return;
        if (a == 12'h7A0) begin
            m_sel = wd;
            return;
        end
        if (a < 12'h7A1 || a > 12'h7A3) return;
        if (m_sel >= 32'(NS)) return;
        idx = int'(m_sel);
        if (ty(idx) == 4'h0) return;
        if (m_own[idx] && !h) return;
        case (a)
            12'h7A1: begin
                m_low[idx] = wd[26:0];
                if (h) m_own[idx] = wd[27];
            end
            12'h7A2: m_d2[idx] = wd;
            default: m_d3[idx] = wd;
        endcase
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(bit we, logic [11:0] a, logic [31:0] wd, bit h, bit m, string tag);
        @(negedge clk);
        csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = wd;
        req_halt = h; req_mach = m;
        #1;
        if (!we) begin
            check(tag, csr_rdata, exp_rd(a));
            check({tag, " hit"}, {31'h0, csr_hit},
                  {31'h0, (a >= 12'h7A0 && a <= 12'h7A3)});
        end
        @(posedge clk);
        #1;
        if (we) model_wr(a, wd, h, m);
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic check_outputs(string tag);
        #1;
        for (int i = 0; i < NS; i++) begin
            check(tag, slot_cfg1[i*XLEN +: XLEN], exp_cfg(i, 1));
            check(tag, slot_cfg2[i*XLEN +: XLEN], exp_cfg(i, 2));
            check(tag, slot_cfg3[i*XLEN +: XLEN], exp_cfg(i, 3));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        m_sel = '0;
        for (int i = 0; i < NS; i++) begin
            m_own[i] = 1'b0; m_low[i] = '0; m_d2[i] = '0; m_d3[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state
        check_outputs("R8 reset outputs");
        acc(0, 12'h7A0, 0, 0, 1, "R8 select after reset");
        acc(0, 12'h7A1, 0, 0, 1, "R2 slot0 type");

        // R2, R3, R5: machine write to data-1 of the count slot
        acc(1, 12'h7A0, 32'd2, 0, 1, "R9 select 2");
        acc(1, 12'h7A1, 32'hFFFF_FFFF, 0, 1, "R5 mach d1");
        acc(0, 12'h7A1, 0, 0, 1, "R5 own unchanged, R2 type kept");
        check("R2 literal", exp_rd(12'h7A1), 32'h37FF_FFFF);
        acc(1, 12'h7A3, 32'hA5A5_0001, 0, 1, "R3 d3 write");
        acc(0, 12'h7A3, 0, 0, 1, "R3 d3 next cycle");

        // R4: halt claims slot, machine writes bounce
        acc(1, 12'h7A1, 32'h0800_0123, 1, 0, "R5 halt claim");
        acc(0, 12'h7A1, 0, 0, 1, "R5 own set");
        acc(1, 12'h7A1, 32'h0000_0456, 0, 1, "R4 locked d1");
        acc(1, 12'h7A2, 32'h0000_1234, 0, 1, "R4 locked d2");
        acc(1, 12'h7A3, 32'h0000_5678, 0, 1, "R4 locked d3");
        acc(0, 12'h7A1, 0, 0, 1, "R4 d1 held");
        acc(0, 12'h7A2, 0, 0, 1, "R4 d2 held");
        acc(0, 12'h7A3, 0, 0, 1, "R4 d3 held");
        acc(1, 12'h7A2, 32'hCAFE_0002, 1, 1, "R4 halt d2");
        acc(0, 12'h7A2, 0, 0, 0, "R4 halt write landed");
        acc(1, 12'h7A1, 32'h0000_0007, 1, 0, "R5 halt release");
        acc(0, 12'h7A1, 0, 1, 0, "R5 own cleared");

        // R6: unprivileged writers
        acc(1, 12'h7A0, 32'd0, 0, 0, "R6 sel drop");
        acc(0, 12'h7A0, 0, 0, 0, "R6 sel kept");
        acc(1, 12'h7A2, 32'h1111_1111, 0, 0, "R6 d2 drop");
        acc(0, 12'h7A2, 0, 0, 0, "R6 d2 kept");

        // R7: type-0 slot and out-of-range selects
        acc(1, 12'h7A0, 32'd4, 1, 0, "R7 select empty slot");
        acc(1, 12'h7A2, 32'hFFFF_FFFF, 1, 0, "R7 empty write");
        acc(0, 12'h7A2, 0, 1, 0, "R7 empty reads zero");
        acc(0, 12'h7A1, 0, 1, 0, "R7 empty d1 zero");
        acc(1, 12'h7A0, 32'd7, 1, 0, "R7 select 7");
        acc(1, 12'h7A1, 32'hFFFF_FFFF, 1, 0, "R7 oor write");
        acc(0, 12'h7A1, 0, 1, 0, "R7 oor d1 zero");
        acc(1, 12'h7A0, 32'd0, 1, 0, "R7 back to 0");
        acc(0, 12'h7A1, 0, 1, 0, "R7 no alias into slot0");
        check_outputs("R7 outputs after oor");

        // R1: outside the window
        acc(0, 12'h7A4, 0, 1, 0, "R1 outside read");
        acc(1, 12'h79F, 32'hFFFF_FFFF, 1, 0, "R1 outside write");
        acc(0, 12'h7A0, 0, 1, 0, "R1 select untouched");

        // R9: full-width select readback
        acc(1, 12'h7A0, 32'hDEAD_BEEF, 0, 1, "R9 wide select");
        acc(0, 12'h7A0, 0, 0, 1, "R9 readback");
        acc(0, 12'h7A3, 0, 0, 1, "R7 wide select zero");

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            bit h, m;
            op = int'($urandom % 8);
            h = 1'($urandom % 2);
            m = 1'($urandom % 2);
            case (op)
                0: acc(1, 12'h7A0, 32'($urandom % 7), h, m, "R3 rand sel");
                1, 2, 3: acc(1, 12'h7A0 + 12'(op), $urandom, h, m, "R3 rand wr");
                default: acc(0, 12'h7A0 + 12'($urandom % 5), 0, h, m, "R3 rand rd");
            endcase
        end
        check_outputs("R3 outputs after random");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule